// File: doc/BRIEF.md
# Floating-Point Status and Trap Control Register

This block holds the status and control word of a floating-point unit. Each time the arithmetic datapath finishes an operation it presents five raw exception indications together with a completion strobe. The block rebuilds the per-operation cause field from them. It merges the same bits into a sticky flag field. If any cause is also enabled, it requests a trap that carries a fixed vector code.

Software can overwrite the whole word. Only the writable bits are kept, and every other bit reads as zero. Two decoded controls, a round-toward-zero select and a denormal flush request, go back to the datapath.

One operation gets special treatment: the approximate reciprocal square root. If the datapath reports no exception for it, the block records an inexact result anyway.

Top module: `fpsr_ctrl`

## Requirements
- R1: After synchronous reset the whole status word reads zero, and the trap request and trap code outputs are low.
- R2: On each completion strobe without a write, the cause field (bits 16:12) is replaced by the new exception set, and old cause bits are dropped. Within every 5-bit field the bit order is: bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid.
- R3: Each new cause bit is ORed into the matching bit of the flag field (bits 6:2). Completions never clear a flag bit.
- R4: For a reciprocal-square-root completion that reports no exception, the inexact cause is forced to 1. If any exception is reported, the reported set is used unchanged.
- R5: A trap request is raised when the new cause field ANDed with the enable field (bits 11:7) is nonzero. While the request is high, the trap code output equals 0x120; otherwise the code is zero.
- R6: A software write stores the written value ANDed with a mask of bits 21:0. Bits 31:22 always read zero.
- R7: The round-toward-zero output is high exactly when the rounding field (bits 1:0) equals 2'b01. Every other value means round-to-nearest-even.
- R8: The flush-denormal output follows bit 18 of the word.
- R9: The trap request is a one-cycle pulse in the cycle after the completion strobe. It is low in any cycle that does not follow a completion.
- R10: A completion with no exception inputs, on a non-reciprocal-square-root operation, leaves the cause field zero, leaves the flags unchanged and raises no trap.
- R11: If a write and a completion arrive in the same cycle, the write wins. That completion changes nothing and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Raw exceptions of the completed operation |
| op_is_rsqrt | input | 1 | Completed operation was a reciprocal square root |
| csr_rdata | output | 32 | Current status word |
| trap_req | output | 1 | Trap request pulse |
| trap_code | output | 12 | Trap vector code |
| rnd_to_zero | output | 1 | Datapath rounds toward zero |
| flush_denorm | output | 1 | Datapath flushes denormals to zero |

## Verification
The status word is visible on the read port in every cycle. A wrong cause, flag or enable bit therefore shows up at the ports one cycle after the completion or write that corrupted it. A lost flag bit stays wrong until software rewrites the word, so it keeps showing. A wrong trap decision appears as a missing or extra pulse in that same following cycle. The bench compares every output against a behavioural model on each clock, so a fault is caught at the first cycle it reaches the port.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int EXC_W      = 5;
    localparam int FIELD_W    = 22;
    localparam int TRAP_W     = 12;
    localparam logic [TRAP_W-1:0] TRAP_VEC = 12'h120;

    // Exception set; member order fixes the bit order inside every field.
    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_t;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_RSV2    = 2'b10,
        RM_RSV3    = 2'b11
    } rmode_e;

    // Writable part of the word, bits 21:0.
    typedef struct packed {
        logic [2:0] spare_hi;   // 21:19
        logic       denorm;     // 18
        logic       spare_lo;   // 17
        exc_t       cause;      // 16:12
        exc_t       enable;     // 11:7
        exc_t       flag;       // 6:2
        rmode_e     rmode;      // 1:0
    } csr_t;

    function automatic logic [EXC_W-1:0] exc_bits(input exc_t e);
        return e;
    endfunction

    function automatic logic any_hit(input exc_t a, input exc_t b);
        return |(exc_bits(a) & exc_bits(b));
    endfunction

    function automatic logic exc_none(input exc_t e);
        return exc_bits(e) == '0;
    endfunction

endpackage

// File: rtl/fpsr_cause_gen.sv
module fpsr_cause_gen
    import fpsr_pkg::*;
(
    input  exc_t raw,
    input  logic is_rsqrt,
    output exc_t cause
);
    // R4: an approximation with no reported exception is still inexact.
    always_comb begin
        cause = raw;
        if (is_rsqrt && exc_none(raw)) begin
            cause.inexact = 1'b1;
        end
    end
endmodule

// File: rtl/fpsr_csr_reg.sv
module fpsr_csr_reg
    import fpsr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    input  exc_t              op_cause,
    output logic [DATA_W-1:0] csr_q,
    output logic              trap_q
);
    localparam logic [DATA_W-1:0] WMASK =
        {{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

    csr_t              cur;
    csr_t              upd;
    logic [EXC_W-1:0]  flag_old;
    logic [EXC_W-1:0]  cause_new;
    logic [EXC_W-1:0]  flag_merged;
    logic [DATA_W-1:0] csr_d;
    logic              trap_d;

    assign cur       = csr_t'(csr_q[FIELD_W-1:0]);
    assign flag_old  = exc_bits(cur.flag);
    assign cause_new = exc_bits(op_cause);

    // R3: sticky merge, one OR per flag bit.
    for (genvar i = 0; i < EXC_W; i++) begin : g_sticky
        assign flag_merged[i] = flag_old[i] | cause_new[i];
    end

    always_comb begin
        upd       = cur;
        upd.cause = op_cause;
        upd.flag  = exc_t'(flag_merged);
    end

    // R11: write has priority over a completion in the same cycle.
    always_comb begin
        csr_d  = csr_q;
        trap_d = 1'b0;
        if (wr_en) begin
            csr_d = wr_data & WMASK;
        end else if (op_done) begin
            csr_d  = {csr_q[DATA_W-1:FIELD_W], upd};
            trap_d = any_hit(op_cause, cur.enable);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q  <= '0;
            trap_q <= 1'b0;
        end else begin
            csr_q  <= csr_d;
            trap_q <= trap_d;
        end
    end
endmodule

// File: rtl/fpsr_mode_dec.sv
module fpsr_mode_dec
    import fpsr_pkg::*;
(
    input  csr_t csr,
    output logic rnd_to_zero,
    output logic flush_denorm
);
    always_comb begin
        unique case (csr.rmode)
            RM_ZERO: rnd_to_zero = 1'b1;
            default: rnd_to_zero = 1'b0;
        endcase
        flush_denorm = csr.denorm;
    end
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
    import fpsr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic              op_is_rsqrt,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              trap_req,
    output logic [TRAP_W-1:0] trap_code,
    output logic              rnd_to_zero,
    output logic              flush_denorm
);
    exc_t              cause_w;
    logic [DATA_W-1:0] csr_q;
    logic              trap_q;

    fpsr_cause_gen u_cause (
        .raw      (exc_t'(op_exc)),
        .is_rsqrt (op_is_rsqrt),
        .cause    (cause_w)
    );

    fpsr_csr_reg #(.DATA_W(DATA_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .op_done  (op_done),
        .op_cause (cause_w),
        .csr_q    (csr_q),
        .trap_q   (trap_q)
    );

    fpsr_mode_dec u_mode (
        .csr          (csr_t'(csr_q[FIELD_W-1:0])),
        .rnd_to_zero  (rnd_to_zero),
        .flush_denorm (flush_denorm)
    );

    assign csr_rdata = csr_q;
    assign trap_req  = trap_q;
    assign trap_code = trap_q ? TRAP_VEC : '0;
endmodule

// File: rtl/fpsr_ctrl_chk.sv
module fpsr_ctrl_chk
    import fpsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic              op_done,
    input logic [EXC_W-1:0]  op_exc,
    input logic              op_is_rsqrt,
    input logic [31:0]       csr_rdata,
    input logic              trap_req,
    input logic [TRAP_W-1:0] trap_code,
    input logic              rnd_to_zero,
    input logic              flush_denorm
);
    p_cause_replaced_r2: assert property (@(posedge clk) disable iff (rst)
        (op_done && !wr_en) |=> csr_rdata[16:12] ==
            (($past(op_is_rsqrt) && $past(op_exc) == 5'b0) ? 5'b00001 : $past(op_exc)));

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (csr_rdata[6:2] & $past(csr_rdata[6:2])) == $past(csr_rdata[6:2]));

    p_rsqrt_inexact_r4: assert property (@(posedge clk) disable iff (rst)
        (op_done && !wr_en && op_is_rsqrt && op_exc == 5'b0) |=> csr_rdata[12]);

    p_trap_rule_r5: assert property (@(posedge clk) disable iff (rst)
        (op_done && !wr_en) |=> trap_req == |(csr_rdata[16:12] & csr_rdata[11:7]));

    p_trap_code_r5: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> trap_code == 12'h120);

    p_write_mask_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> csr_rdata == ($past(wr_data) & 32'h003F_FFFF));

    p_round_decode_r7: assert property (@(posedge clk) disable iff (rst)
        rnd_to_zero == (csr_rdata[1:0] == 2'b01));

    p_denorm_r8: assert property (@(posedge clk) disable iff (rst)
        flush_denorm == csr_rdata[18]);

    p_trap_only_after_op_r9: assert property (@(posedge clk) disable iff (rst)
        !(op_done && !wr_en) |=> !trap_req);
endmodule

bind fpsr_ctrl fpsr_ctrl_chk u_chk (.*);

// File: tb/sim_fpsr_ctrl.sv
module sim_fpsr_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_is_rsqrt = 1'b0;
    logic [31:0] csr_rdata;
    logic        trap_req;
    logic [11:0] trap_code;
    logic        rnd_to_zero;
    logic        flush_denorm;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fpsr_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_exc(op_exc), .op_is_rsqrt(op_is_rsqrt),
        .csr_rdata(csr_rdata), .trap_req(trap_req), .trap_code(trap_code),
        .rnd_to_zero(rnd_to_zero), .flush_denorm(flush_denorm)
    );

    // Behavioural reference model of the status word.
    logic [31:0] m_csr;
    logic        m_trap;
    logic [4:0]  m_e;
    always @(posedge clk) begin
        if (rst) begin
            m_csr  <= '0;
            m_trap <= 1'b0;
        end else if (wr_en) begin
            m_csr  <= wr_data & 32'h003F_FFFF;
            m_trap <= 1'b0;
        end else if (op_done) begin
            m_e = op_exc;
            if (op_is_rsqrt && m_e == 5'd0) m_e = 5'b00001;
            m_csr  <= {m_csr[31:17], m_e, m_csr[11:7], m_csr[6:2] | m_e, m_csr[1:0]};
            m_trap <= (m_e & m_csr[11:7]) != 5'd0;
        end else begin
            m_trap <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2 cause", {27'd0, csr_rdata[16:12]}, {27'd0, m_csr[16:12]});
            check("R3 flags", {27'd0, csr_rdata[6:2]}, {27'd0, m_csr[6:2]});
            check("R6 word", csr_rdata, m_csr);
            check("R5 trap", {31'd0, trap_req}, {31'd0, m_trap});
            check("R5 code", {20'd0, trap_code}, m_trap ? 32'h120 : 32'h0);
            check("R7 round", {31'd0, rnd_to_zero}, {31'd0, m_csr[1:0] == 2'b01});
            check("R8 denorm", {31'd0, flush_denorm}, {31'd0, m_csr[18]});
        end
    end

    task automatic do_write(input logic [31:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_op(input logic [4:0] e, input logic rs);
        @(posedge clk); #1;
        op_done = 1'b1; op_exc = e; op_is_rsqrt = rs;
        @(posedge clk); #1;
        op_done = 1'b0; op_exc = '0; op_is_rsqrt = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 word", csr_rdata, 32'h0);
        check("R1 trap", {31'd0, trap_req}, 32'h0);
        check("R1 code", {20'd0, trap_code}, 32'h0);

        // R6: mask
        do_write(32'hFFFF_FFFF);
        check("R6 mask", csr_rdata, 32'h003F_FFFF);
        // R7 / R8 decodes
        do_write(32'h0000_0001);
        check("R7 rtz", {31'd0, rnd_to_zero}, 32'h1);
        do_write(32'h0004_0003);
        check("R7 rm3", {31'd0, rnd_to_zero}, 32'h0);
        check("R8 flush", {31'd0, flush_denorm}, 32'h1);

        // Enable divide-by-zero (enable bit 10).
        do_write(32'h0000_0400);
        do_op(5'b01000, 1'b0);
        check("R5 trap", {31'd0, trap_req}, 32'h1);
        check("R5 code", {20'd0, trap_code}, 32'h120);
        check("R2 cause", {27'd0, csr_rdata[16:12]}, 32'h8);
        @(negedge clk);
        check("R9 pulse", {31'd0, trap_req}, 32'h0);

        // R10: no exception, cause cleared, flags kept, no trap
        do_op(5'b00000, 1'b0);
        check("R10 cause", {27'd0, csr_rdata[16:12]}, 32'h0);
        check("R10 flags", {27'd0, csr_rdata[6:2]}, 32'h8);
        check("R10 trap", {31'd0, trap_req}, 32'h0);

        // R4: rsqrt forcing
        do_op(5'b00000, 1'b1);
        check("R4 forced", {27'd0, csr_rdata[16:12]}, 32'h1);
        do_op(5'b00100, 1'b1);
        check("R4 kept", {27'd0, csr_rdata[16:12]}, 32'h4);
        check("R3 sticky", {27'd0, csr_rdata[6:2]}, 32'hD);

        // R11: write and completion in the same cycle
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = 32'h0000_0F80;
        op_done = 1'b1; op_exc = 5'b11111;
        @(posedge clk); #1;
        wr_en = 1'b0; op_done = 1'b0; op_exc = '0;
        @(negedge clk);
        check("R11 word", csr_rdata, 32'h0000_0F80);
        check("R11 trap", {31'd0, trap_req}, 32'h0);

        // Random traffic compared each cycle against the model.
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            wr_en       = ($urandom % 16) == 0;
            wr_data     = $urandom;
            op_done     = ($urandom % 2) == 0;
            op_exc      = (($urandom % 3) == 0) ? 5'd0 : 5'($urandom);
            op_is_rsqrt = ($urandom % 4) == 0;
        end
        @(posedge clk); #1;
        wr_en = 1'b0; op_done = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule